// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps time as a free-running 32-bit count of seconds. An internal prescaler divides the system clock by `CLK_HZ` to produce a one-cycle seconds enable, and each enable advances the count by one. The count wraps from all-ones to zero. Software can preset the count at any time through a load register. Writing the load register also restarts the prescaler, so the first increment after a load comes one full second later.

A programmable alarm value is compared against the count. When the two become equal, a sticky raw alarm flag is set. It stays set until software writes a 1 to bit 0 of the clear register. A one-bit mask gates the flag onto a registered interrupt line. Writing the alarm value or the load register re-runs the comparison at once.

Software reaches the block over an APB-style port with zero wait states. Read data is captured in the setup phase and is valid in the access phase. A block of read-only identification words sits at the top of the 4 KiB window.

Top module: `sec_rtc`

## Requirements
- R1: The count (read at offset 0x00) advances by exactly one every `CLK_HZ` clock cycles and wraps from 0xFFFFFFFF to 0.
- R2: A write to offset 0x08 sets the count to the written value and restarts the prescaler. The first increment follows exactly `CLK_HZ` cycles after the write edge. Reading 0x08 returns the last value written there.
- R3: When an increment makes the count equal to the alarm value (offset 0x04, read/write), the raw flag (bit 0 of offset 0x14) is set and stays set until it is cleared. This includes an alarm value that is reached only after the count wraps.
- R4: If the count equals the alarm value right after a write to 0x04 or 0x08, the raw flag is set on that same write edge.
- R5: Only bit 0 of the mask register (offset 0x10) is stored. The masked status (bit 0 of offset 0x18) and the `irq` output both equal raw AND mask. `irq` is a register output.
- R6: Writing offset 0x1C with bit 0 set clears the raw flag. Writing it with bit 0 at 0 leaves the flag unchanged. Reads of 0x1C return 0.
- R7: When a set condition and a clear write fall on the same edge, the raw flag ends up set.
- R8: Offset 0x0C always reads 1, and writes to it have no effect. Writes to offsets 0x00, 0x14 and 0x18 change nothing.
- R9: Word reads from 0xFE0 to 0xFFC return, in address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Every other unmapped offset reads 0.
- R10: After reset, count, alarm value, load value, mask, raw flag, `prdata` and `irq` are all 0. No alarm fires until a load write, an alarm write or a count change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, `CLK_HZ` cycles per second |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Word address, byte offset bits 11:2 |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Tied high, no wait states |
| irq | output | 1 | Registered alarm interrupt |

## Verification
The embedded properties check the following on every cycle:
- the increment step and the spacing of the seconds enable;
- the load landing in the count;
- stickiness of the raw flag;
- an immediate set when a load matches the alarm;
- set-over-clear priority;
- agreement between `irq` and raw AND mask;
- the constant control read.

Other behaviours show up only through the bench's scenarios:
- the exact cycle of the first increment after a load;
- alarms that fire only after the count wraps;
- writes to read-only offsets leaving state untouched;
- the identification bytes and unmapped reads.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  // word indices (byte offset >> 2)
  localparam logic [9:0] W_COUNT = 10'h000;
  localparam logic [9:0] W_ALARM = 10'h001;
  localparam logic [9:0] W_LOAD  = 10'h002;
  localparam logic [9:0] W_CTRL  = 10'h003;
  localparam logic [9:0] W_MASK  = 10'h004;
  localparam logic [9:0] W_RAW   = 10'h005;
  localparam logic [9:0] W_MSKD  = 10'h006;
  localparam logic [9:0] W_CLR   = 10'h007;
  localparam logic [6:0] W_IDHI  = 7'h7F;  // 0xFE0..0xFFF

  typedef struct packed {
    logic load;
    logic alarm;
    logic mask;
    logic clr;
  } wr_strb_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/sec_rtc_prescale.sv
module sec_rtc_prescale #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

  generate
    if (CLK_HZ <= 1) begin : g_pass
      assign tick = ~restart;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);

      // R1
      gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  sec_rtc_pkg::wr_strb_t  strb,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          count_q,
  output logic [DW-1:0]          alarm_q,
  output logic                   mask_q,
  output logic                   raw_q,
  output logic                   irq_q
);
  logic [DW-1:0] count_nx, alarm_nx;
  logic          eval, hit, raw_nx, mask_nx, clr_hit;

  always_comb begin
    if (strb.load)  count_nx = wdata;
    else if (tick)  count_nx = count_q + 1'b1;
    else            count_nx = count_q;
    alarm_nx = strb.alarm ? wdata : alarm_q;
    mask_nx  = strb.mask ? wdata[0] : mask_q;
    eval     = strb.load | strb.alarm | tick;
    hit      = eval && (count_nx == alarm_nx);
    clr_hit  = strb.clr & wdata[0];
    raw_nx   = hit | (raw_q & ~clr_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      alarm_q <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_nx;
      alarm_q <= alarm_nx;
      mask_q  <= mask_nx;
      raw_q   <= raw_nx;
      irq_q   <= raw_nx & mask_nx;
    end
  end

  // R1
  inc_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !strb.load) |=> count_q == $past(count_q) + 1'b1);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> count_q == $past(wdata));
  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_q && !(strb.clr && wdata[0])) |=> raw_q);
  // R4
  ldmatch_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && !strb.alarm && wdata == alarm_q) |=> raw_q);
  // R5
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (raw_q & mask_q));
  // R7
  prio_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !strb.load && !strb.alarm && (count_q + 1'b1) == alarm_q) |=> raw_q);
endmodule

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs #(
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [11:2]           paddr,
  input  logic [DW-1:0]         pwdata,
  input  logic [DW-1:0]         count,
  input  logic [DW-1:0]         alarm,
  input  logic                  mask,
  input  logic                  raw,
  output sec_rtc_pkg::wr_strb_t strb,
  output logic [DW-1:0]         prdata
);
  import sec_rtc_pkg::*;

  logic          wr_acc, rd_setup;
  logic [DW-1:0] load_q, rd_mux;

  assign wr_acc   = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;

  always_comb begin
    strb.load  = wr_acc && (paddr == W_LOAD);
    strb.alarm = wr_acc && (paddr == W_ALARM);
    strb.mask  = wr_acc && (paddr == W_MASK);
    strb.clr   = wr_acc && (paddr == W_CLR);
  end

  always_ff @(posedge clk) begin
    if (rst) load_q <= '0;
    else if (strb.load) load_q <= pwdata;
  end

  always_comb begin
    rd_mux = '0;
    case (paddr)
      W_COUNT: rd_mux = count;
      W_ALARM: rd_mux = alarm;
      W_LOAD:  rd_mux = load_q;
      W_CTRL:  rd_mux = DW'(1);
      W_MASK:  rd_mux = DW'(mask);
      W_RAW:   rd_mux = DW'(raw);
      W_MSKD:  rd_mux = DW'(raw & mask);
      default: begin
        if (paddr[11:5] == W_IDHI) rd_mux = DW'(id_byte(paddr[4:2]));
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end

  // R8
  ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && paddr == W_CTRL) |=> prdata == DW'(1));
  // R6
  clrrd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && paddr == W_CLR) |=> prdata == '0);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int CLK_HZ = 50_000_000,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [11:2]   paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          irq
);
  sec_rtc_pkg::wr_strb_t strb;
  logic          tick, mask, raw;
  logic [DW-1:0] count, alarm;

  assign pready = 1'b1;

  sec_rtc_prescale #(.CLK_HZ(CLK_HZ)) u_pre (
    .clk(clk), .rst(rst), .restart(strb.load), .tick(tick)
  );

  sec_rtc_alarm #(.DW(DW)) u_alm (
    .clk(clk), .rst(rst), .tick(tick), .strb(strb), .wdata(pwdata),
    .count_q(count), .alarm_q(alarm), .mask_q(mask), .raw_q(raw), .irq_q(irq)
  );

  sec_rtc_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .count(count), .alarm(alarm),
    .mask(mask), .raw(raw), .strb(strb), .prdata(prdata)
  );
endmodule

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 16;

  logic        clk = 1'b0, rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:2] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready, irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  sec_rtc #(.CLK_HZ(HZ)) u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares read data in the access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite && exp_q.size() > 0)
      chk(tag_q.pop_front(), prdata, exp_q.pop_front());
  end

  task automatic rd(input logic [11:0] off, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = 0; paddr = off[11:2];
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = 1; paddr = off[11:2]; pwdata = d;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10 reset state
    chk("R10 irq", {31'd0, irq}, 0);
    chk("R10 pready", {31'd0, pready}, 1);
    rd(12'h000, 0, "R10 count");
    rd(12'h004, 0, "R10 alarm");
    rd(12'h008, 0, "R10 load");
    rd(12'h010, 0, "R10 mask");
    rd(12'h014, 0, "R10 raw");
    rd(12'h018, 0, "R10 masked");
    // R2 load and readback, prescaler restart
    wr(12'h008, 100);
    rd(12'h000, 100, "R2 count after load");
    rd(12'h008, 100, "R2 load readback");
    wr(12'h008, 200);
    repeat (14) @(posedge clk);
    rd(12'h000, 200, "R2 no early increment");
    rd(12'h000, 201, "R1 one increment");
    // R4 alarm write matches count
    wr(12'h008, 500);
    wr(12'h004, 500);
    rd(12'h014, 1, "R4 alarm write sets raw");
    rd(12'h004, 500, "R3 alarm readback");
    // R6 clear behaviour
    wr(12'h01C, 0);
    rd(12'h014, 1, "R6 clear with bit0=0 keeps");
    wr(12'h01C, 1);
    rd(12'h014, 0, "R6 clear with bit0=1");
    rd(12'h01C, 0, "R6 clear reads 0");
    // R4 via load
    wr(12'h004, 700);
    rd(12'h014, 0, "R4 no set on mismatch");
    wr(12'h008, 700);
    rd(12'h014, 1, "R4 load write sets raw");
    wr(12'h01C, 1);
    // R3 increment reaches alarm, R5 masking
    wr(12'h008, 1000);
    wr(12'h004, 1002);
    rd(12'h014, 0, "R3 not yet");
    repeat (40) @(posedge clk);
    rd(12'h014, 1, "R3 raw after increments");
    rd(12'h018, 0, "R5 masked while mask 0");
    @(negedge clk); chk("R5 irq masked", {31'd0, irq}, 0);
    wr(12'h010, 32'hFFFF_FFFF);
    @(negedge clk); chk("R5 irq raised", {31'd0, irq}, 1);
    rd(12'h010, 1, "R5 only bit0 stored");
    rd(12'h018, 1, "R5 masked status");
    wr(12'h01C, 1);
    @(negedge clk); chk("R5 irq drops on clear", {31'd0, irq}, 0);
    // R1/R3 wrap
    wr(12'h004, 0);
    wr(12'h008, 32'hFFFF_FFFE);
    wr(12'h01C, 1);
    rd(12'h014, 0, "R3 no early wrap fire");
    repeat (40) @(posedge clk);
    rd(12'h014, 1, "R1 wrap to alarm 0");
    wr(12'h01C, 1);
    // R7 set beats clear on same edge
    wr(12'h004, 5000);
    wr(12'h01C, 1);
    wr(12'h008, 4999);
    repeat (13) @(posedge clk);
    wr(12'h01C, 1);
    rd(12'h014, 1, "R7 set over clear");
    wr(12'h01C, 1);
    // R8 ignored writes
    wr(12'h008, 3000);
    wr(12'h000, 7);
    rd(12'h000, 3000, "R8 count write ignored");
    wr(12'h014, 1);
    rd(12'h014, 0, "R8 raw write ignored");
    wr(12'h018, 1);
    rd(12'h018, 0, "R8 masked write ignored");
    wr(12'h00C, 0);
    rd(12'h00C, 1, "R8 control reads 1");
    // R9 identification and unmapped
    rd(12'hFE0, 32'h31, "R9 id0");
    rd(12'hFE4, 32'h10, "R9 id1");
    rd(12'hFE8, 32'h14, "R9 id2");
    rd(12'hFEC, 32'h00, "R9 id3");
    rd(12'hFF0, 32'h0D, "R9 id4");
    rd(12'hFF4, 32'hF0, "R9 id5");
    rd(12'hFF8, 32'h05, "R9 id6");
    rd(12'hFFC, 32'hB1, "R9 id7");
    rd(12'h020, 0, "R9 unmapped low");
    rd(12'h800, 0, "R9 unmapped mid");
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule